// File: doc/BRIEF.md
# SD Host Transfer State Tracker

This block holds the live data-phase status of an SD/SDIO host controller. It receives one-cycle event strobes from the command engine and the data engine, plus the card busy level and per-cycle byte counts moved into and out of the data buffer. From these it keeps six status flags: block ready to read, room to write a block, read in progress, write in progress, data lines in use, and data command inhibit. It also raises two interrupt pulses: one when a readable block appears and one when the inhibit flag drops.

Software reads the flags to pace buffer access and to decide when a new data command may be issued. The interrupt pulses feed the controller's interrupt status logic. A stop at a block gap pauses whichever transfer is running. A later continue request resumes it. On a write, the data lines are not released until the card has shown not-busy for a qualified run of cycles.

Top module: `sd_xfer_tracker`

## Requirements
- R1: After hardware reset, or on a cycle with `soft_rst` high, every flag, the buffer byte level, the busy-cycle counter, the pause state and both interrupt outputs are 0. The only exception is `wr_space`, which follows R3. No interrupt pulse results from the clear.
- R2: `rd_rdy` is 1 exactly when `blk_len` is nonzero and the buffer level is at least `blk_len`. The level starts at 0 and each clock adds `fill_n` and subtracts `drain_n`. `brr_irq` is 1 for the single cycle in which `rd_rdy` first reads 1 after reading 0.
- R3: `wr_space` is 1 exactly when DEPTH minus the buffer level is at least `blk_len`.
- R4: `rta` sets on `rd_cmd_end`. It clears one cycle after the buffer level is 0, provided `rd_last_end` has been seen since the read started. It also clears on `gap_hit`, and the read is then paused.
- R5: `wta` sets on `wr_cmd_end`. It clears on `crc_stat` while `last_blk` is 1, and also on `gap_hit`, after which the write is paused.
- R6: In a read, `dla` sets with `rta`. It clears on `rd_last_end` or on `rd_wait`. A stop at a block gap alone leaves it set.
- R7: In a write, `dla` clears only after NB consecutive clocks with `card_busy` low. The count starts after the clock that ends the last block (`crc_stat` with `last_blk`) or the clock that reaches a block gap. Any clock with `card_busy` high restarts the count. NB defaults to 8.
- R8: `inhibit` equals `dla` OR `rta` OR a busy command outstanding. A busy command is outstanding from `busy_cmd_iss` until `busy_cmd_done`.
- R9: `tc_irq` is 1 for exactly the one cycle after `inhibit` goes from 1 to 0.
- R10: `cont_req` resumes only a paused transfer: it sets `rta` (read) or `wta` (write), together with `dla`. With nothing paused it has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset of all tracking state |
| blk_len | input | 11 | Programmed block length in bytes |
| fill_n | input | BW | Bytes written into the buffer this cycle |
| drain_n | input | BW | Bytes taken from the buffer this cycle |
| rd_cmd_end | input | 1 | End bit of a read data command |
| wr_cmd_end | input | 1 | End bit of a write data command |
| cont_req | input | 1 | Continue request after a block-gap stop |
| gap_hit | input | 1 | Stop at block gap reached |
| rd_last_end | input | 1 | End bit of the last read block received |
| rd_wait | input | 1 | Read-wait entered |
| crc_stat | input | 1 | CRC status token received from card |
| last_blk | input | 1 | Current write block is the last one |
| card_busy | input | 1 | Card holds data line 0 busy |
| busy_cmd_iss | input | 1 | Command with busy response issued |
| busy_cmd_done | input | 1 | Busy of that command has ended |
| rd_rdy | output | 1 | A full block is readable |
| wr_space | output | 1 | Room for a full block |
| rta | output | 1 | Read transfer active |
| wta | output | 1 | Write transfer active |
| dla | output | 1 | Data lines active |
| inhibit | output | 1 | Data command inhibit |
| brr_irq | output | 1 | Read-ready interrupt pulse |
| tc_irq | output | 1 | Transfer complete interrupt pulse |

## Verification
The assertions take for granted that the buffer never underflows or overflows. Each cycle's drain must not exceed the current level, and each fill must fit in the space left. They also take for granted that a read command end and a write command end never arrive in the same cycle. The random stimulus keeps its byte counts inside a reference level model, so both buffer bounds hold. The directed sequences apply one protocol event per cycle, in orders a real SD exchange can produce.

// File: rtl/sd_xfer_tracker.sv
module sd_xfer_tracker #(
  parameter int DEPTH = 4096,
  parameter int BEAT  = 4,
  parameter int NB    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int BW   = $clog2(BEAT + 1),
  localparam int CW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [10:0]   blk_len,
  input  logic [BW-1:0] fill_n,
  input  logic [BW-1:0] drain_n,
  input  logic          rd_cmd_end,
  input  logic          wr_cmd_end,
  input  logic          cont_req,
  input  logic          gap_hit,
  input  logic          rd_last_end,
  input  logic          rd_wait,
  input  logic          crc_stat,
  input  logic          last_blk,
  input  logic          card_busy,
  input  logic          busy_cmd_iss,
  input  logic          busy_cmd_done,
  output logic          rd_rdy,
  output logic          wr_space,
  output logic          rta,
  output logic          wta,
  output logic          dla,
  output logic          inhibit,
  output logic          brr_irq,
  output logic          tc_irq
);

  logic [LW-1:0] level;
  logic [CW-1:0] nb_cnt;
  logic dir_wr, pause_rd, pause_wr, last_seen, qual_arm, bcmd;
  logic rd_rdy_q, inh_q;

  assign rd_rdy   = (blk_len != 11'd0) && (32'(level) >= 32'(blk_len));
  assign wr_space = (32'(DEPTH) - 32'(level)) >= 32'(blk_len);
  assign inhibit  = dla | rta | bcmd;
  assign brr_irq  = rd_rdy & ~rd_rdy_q;
  assign tc_irq   = inh_q & ~inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0; nb_cnt <= '0;
      {dir_wr, pause_rd, pause_wr, last_seen, qual_arm, bcmd} <= '0;
      {rta, wta, dla, rd_rdy_q, inh_q} <= '0;
    end else if (soft_rst) begin
      level <= '0; nb_cnt <= '0;
      {dir_wr, pause_rd, pause_wr, last_seen, qual_arm, bcmd} <= '0;
      {rta, wta, dla, rd_rdy_q, inh_q} <= '0;
    end else begin
      level    <= level + LW'(fill_n) - LW'(drain_n);
      rd_rdy_q <= rd_rdy;
      inh_q    <= inhibit;

      if (!dir_wr && (rd_last_end || rd_wait)) dla <= 1'b0;
      if (!dir_wr && rd_last_end && rta) last_seen <= 1'b1;
      if (rta && last_seen && level == '0) begin
        rta <= 1'b0; last_seen <= 1'b0;
      end

      if (wta && crc_stat && last_blk) begin
        wta <= 1'b0; qual_arm <= 1'b1; nb_cnt <= '0;
      end

      if (gap_hit) begin
        if (rta) begin rta <= 1'b0; pause_rd <= 1'b1; last_seen <= 1'b0; end
        if (wta) begin wta <= 1'b0; pause_wr <= 1'b1; qual_arm <= 1'b1; nb_cnt <= '0; end
      end

      if (qual_arm) begin
        if (card_busy) nb_cnt <= '0;
        else if (nb_cnt == CW'(NB - 1)) begin dla <= 1'b0; qual_arm <= 1'b0; end
        else nb_cnt <= nb_cnt + 1'b1;
      end

      if (rd_cmd_end) begin
        rta <= 1'b1; dla <= 1'b1; dir_wr <= 1'b0; last_seen <= 1'b0;
        pause_rd <= 1'b0; pause_wr <= 1'b0; qual_arm <= 1'b0;
      end
      if (wr_cmd_end) begin
        wta <= 1'b1; dla <= 1'b1; dir_wr <= 1'b1;
        pause_rd <= 1'b0; pause_wr <= 1'b0; qual_arm <= 1'b0;
      end
      if (cont_req && (pause_rd || pause_wr)) begin
        if (pause_rd) rta <= 1'b1;
        if (pause_wr) wta <= 1'b1;
        dla <= 1'b1; pause_rd <= 1'b0; pause_wr <= 1'b0; qual_arm <= 1'b0;
      end

      if (busy_cmd_iss) bcmd <= 1'b1;
      else if (busy_cmd_done) bcmd <= 1'b0;
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= 32'(DEPTH));
  a_r2_brr_single: assert property (@(posedge clk) disable iff (!rst_n)
    brr_irq |=> !brr_irq);
  a_r4_rta_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rta) |-> $past(rd_cmd_end || (cont_req && pause_rd)));
  a_r5_wta_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wta) |-> $past(wr_cmd_end || (cont_req && pause_wr)));
  a_r7_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dla) && $past(dir_wr) && !$past(soft_rst))
      |-> ($past(nb_cnt) == CW'(NB - 1) && !$past(card_busy)));
  a_r9_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);
  a_r9_tc_low_inh: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |-> !inhibit);

endmodule

// File: tb/sd_xfer_tracker_tb.sv
module sd_xfer_tracker_tb_top;
  localparam int DEPTH = 256;
  localparam int BW = 3;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [10:0] blk_len = 11'd16;
  logic [BW-1:0] fill_n = 0, drain_n = 0;
  logic rd_cmd_end = 0, wr_cmd_end = 0, cont_req = 0, gap_hit = 0;
  logic rd_last_end = 0, rd_wait = 0, crc_stat = 0, last_blk = 0;
  logic card_busy = 0, busy_cmd_iss = 0, busy_cmd_done = 0;
  logic rd_rdy, wr_space, rta, wta, dla, inhibit, brr_irq, tc_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_xfer_tracker #(.DEPTH(DEPTH), .BEAT(4), .NB(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .blk_len(blk_len),
    .fill_n(fill_n), .drain_n(drain_n), .rd_cmd_end(rd_cmd_end),
    .wr_cmd_end(wr_cmd_end), .cont_req(cont_req), .gap_hit(gap_hit),
    .rd_last_end(rd_last_end), .rd_wait(rd_wait), .crc_stat(crc_stat),
    .last_blk(last_blk), .card_busy(card_busy), .busy_cmd_iss(busy_cmd_iss),
    .busy_cmd_done(busy_cmd_done), .rd_rdy(rd_rdy), .wr_space(wr_space),
    .rta(rta), .wta(wta), .dla(dla), .inhibit(inhibit),
    .brr_irq(brr_irq), .tc_irq(tc_irq));

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_rdy(int lvl, int bl);
    return (bl != 0) && (lvl >= bl);
  endfunction
  function automatic bit exp_space(int lvl, int bl);
    return (DEPTH - lvl) >= bl;
  endfunction

  function automatic logic [5:0] flags();
    return {rta, wta, dla, inhibit, brr_irq, tc_irq};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 reset flags", flags(), 6'b0);
    chk("R1 reset rd_rdy", rd_rdy, 0);
    chk("R3 reset wr_space", wr_space, 1);

    // read transfer
    rd_cmd_end = 1; cyc(); rd_cmd_end = 0;
    chk("R4 R6 R8 read start", {rta, wta, dla, inhibit}, 4'b1011);
    fill_n = 4; cyc(3);
    chk("R2 not yet ready", rd_rdy, 0);
    cyc(); fill_n = 0;
    chk("R2 block ready", {rd_rdy, brr_irq}, 2'b11);
    cyc();
    chk("R2 brr one cycle", {rd_rdy, brr_irq}, 2'b10);
    rd_last_end = 1; cyc(); rd_last_end = 0;
    chk("R6 dla cleared by last end", {rta, dla, inhibit, tc_irq}, 4'b1010);
    drain_n = 4; cyc(4); drain_n = 0;
    chk("R2 drained", rd_rdy, 0);
    chk("R4 rta waits one cycle", rta, 1);
    cyc();
    chk("R4 rta cleared", rta, 0);
    chk("R9 tc pulse", {inhibit, tc_irq}, 2'b01);
    cyc();
    chk("R9 tc one cycle", tc_irq, 0);

    // write transfer with busy qualification
    wr_cmd_end = 1; cyc(); wr_cmd_end = 0;
    chk("R5 write start", {rta, wta, dla, inhibit}, 4'b0111);
    last_blk = 1; crc_stat = 1; card_busy = 1; cyc(); crc_stat = 0; last_blk = 0;
    chk("R5 wta cleared by crc", {wta, dla}, 2'b01);
    cyc(3);
    card_busy = 0; cyc(5);
    card_busy = 1; cyc(); card_busy = 0;
    cyc(7);
    chk("R7 restart holds dla", {dla, inhibit}, 2'b11);
    cyc();
    chk("R7 dla released after 8", {dla, tc_irq}, 2'b01);

    // read gap, read wait, continue
    rd_cmd_end = 1; cyc(); rd_cmd_end = 0;
    gap_hit = 1; cyc(); gap_hit = 0;
    chk("R4 R6 gap pauses read", {rta, dla}, 2'b01);
    rd_wait = 1; cyc(); rd_wait = 0;
    chk("R6 read wait clears dla", {dla, tc_irq}, 2'b01);
    cont_req = 1; cyc(); cont_req = 0;
    chk("R10 resume read", {rta, wta, dla}, 3'b101);
    fill_n = 4; cyc(2); fill_n = 0;
    soft_rst = 1; cyc(); soft_rst = 0;
    chk("R1 soft reset", flags(), 6'b0);
    chk("R1 soft reset level", rd_rdy, 0);
    blk_len = 11'd4; cyc();
    chk("R1 level cleared", rd_rdy, 0);
    blk_len = 11'd16;
    cont_req = 1; cyc(); cont_req = 0;
    chk("R10 continue ignored", {rta, wta, dla, inhibit}, 4'b0);

    // write gap and resume
    wr_cmd_end = 1; cyc(); wr_cmd_end = 0;
    gap_hit = 1; cyc(); gap_hit = 0;
    chk("R5 gap pauses write", {wta, dla}, 2'b01);
    cyc(7);
    chk("R7 gap busy hold", dla, 1);
    cyc();
    chk("R7 gap release", {dla, tc_irq}, 2'b01);
    cont_req = 1; cyc(); cont_req = 0;
    chk("R10 resume write", {rta, wta, dla}, 3'b011);
    soft_rst = 1; cyc(); soft_rst = 0;

    // busy command
    busy_cmd_iss = 1; cyc(); busy_cmd_iss = 0;
    chk("R8 busy cmd inhibit", {dla, inhibit}, 2'b01);
    busy_cmd_done = 1; cyc(); busy_cmd_done = 0;
    chk("R8 R9 busy cmd done", {inhibit, tc_irq}, 2'b01);

    // random buffer traffic
    begin
      int lvl = 0, bl = 16;
      bit prev;
      void'($urandom(32'd1234));
      blk_len = 11'(bl);
      for (int k = 0; k < 3000; k++) begin
        int f, d;
        if (k % 200 == 0) begin bl = $urandom_range(0, 128); blk_len = 11'(bl); end
        f = $urandom_range(0, 4); d = $urandom_range(0, 4);
        if (f > DEPTH - lvl) f = DEPTH - lvl;
        if (d > lvl) d = lvl;
        fill_n = BW'(f); drain_n = BW'(d);
        prev = exp_rdy(lvl, bl);
        cyc();
        lvl = lvl + f - d;
        chk("R2 random rd_rdy", rd_rdy, exp_rdy(lvl, bl));
        chk("R3 random wr_space", wr_space, exp_space(lvl, bl));
        chk("R2 random brr", brr_irq, exp_rdy(lvl, bl) & ~prev);
      end
      fill_n = 0; drain_n = 0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule